// File: doc/BRIEF.md
# Dual-Port Hardware Semaphore Bank

This block gives two independent processor ports, left and right, a shared bank of eight token flags. The ports use the flags to agree on which of them currently owns a common resource. A port claims a token by writing a 0 on data bit 0. It gives the token back by writing a 1. Each port reads a flag as a status value copied onto its whole data bus. A flag reads 0 on the side that holds the token and 1 everywhere else.

Each side keeps a private request latch per flag. A claim made by the side that did not win is therefore not lost. It waits in that side's latch, and the token passes to that side on the same clock edge at which the owner releases it. When both sides claim a free flag on the same edge, a fixed rule gives the token to the left port. Read data is captured when a read access begins and held until the access ends. A polling loop must drop its select or output enable between polls to see a new value.

Both ports share one clock. Every access is sampled on the rising edge. Outputs are registered and never tri-stated.

Top module: `sema_bank`

## Requirements
- R1: Address bits [2:0] of a port select one of the eight flags. All higher address bits have no effect on a semaphore access.
- R2: A port accesses the bank only on an edge where its semN and ceN are both 0. weN=0 marks a write. weN=1 with oeN=0 marks a read. With semN or ceN at 1, a write leaves the flags unchanged and no read data is produced.
- R3: A write looks only at data bit 0. A value of 0 sets that side's request latch for the addressed flag, and a value of 1 clears it. All other data bits are ignored.
- R4: A request on a free flag gives the token to the requesting side. That side then reads 0 and the other side reads 1. A write of 1 from the non-owning side does not take the token away.
- R5: A 0 written by the non-owning side stays pending in its latch. When the owner writes 1, the token moves to the pending side on that same edge, and that side then reads 0.
- R6: When the owner writes 1 and no request is pending, the flag becomes free and reads 1 on both sides.
- R7: Read data is the addressed flag value for that side, copied onto every data bit: 8'hFF for 1 and 8'h00 for 0.
- R8: On the first edge of a read access, rdData and rdValid=1 load. They stay frozen, even if the flag changes, while the access remains active. On the first edge where the access is not active, rdData returns to 0 and rdValid to 0.
- R9: When both sides request a free flag on the same edge, the left side gets the token. The two sides never hold the same token at once.
- R10: Reset puts both request latches of every flag in the requesting state, with the left side holding the token. A flag reads 1 on both sides only after both sides have written 1 to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock for both ports |
| rstN | input | 1 | Active-low synchronous reset |
| lSemN | input | 1 | Left semaphore select, active low |
| lCeN | input | 1 | Left chip enable, active low |
| lWeN | input | 1 | Left write enable, 0 = write, 1 = read |
| lOeN | input | 1 | Left output enable, active low |
| lAddr | input | ADDR_W (16) | Left address, bits [2:0] select the flag |
| lWrData | input | DATA_W (8) | Left write data, bit 0 used |
| lRdData | output | DATA_W (8) | Left captured read data |
| lRdValid | output | 1 | Left read data valid |
| rSemN | input | 1 | Right semaphore select, active low |
| rCeN | input | 1 | Right chip enable, active low |
| rWeN | input | 1 | Right write enable, 0 = write, 1 = read |
| rOeN | input | 1 | Right output enable, active low |
| rAddr | input | ADDR_W (16) | Right address, bits [2:0] select the flag |
| rWrData | input | DATA_W (8) | Right write data, bit 0 used |
| rRdData | output | DATA_W (8) | Right captured read data |
| rRdValid | output | 1 | Right read data valid |

## Verification
The hardest situation to reach from the ports is a frozen read that covers a change of ownership. The reading side must hold an active read while the other side changes the flag that read is showing. The stimulus gets there in steps. The right side takes a flag and the left side queues a request behind it. The left side then holds a read open across the right side's release. Finally the left side drops and restores its output enable to reveal the token it has silently gained. A long random phase then drives both ports at once on overlapping flags, with high address and data bits scrambled. A behavioural model checks every clock, which covers same-edge ties and handoffs.

// File: rtl/sema_pkg.sv
package sema_pkg;
  localparam int FLAG_IDX_W = 3;
  localparam int NUM_FLAGS  = 1 << FLAG_IDX_W;

  typedef enum logic [1:0] {
    OWN_FREE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } ownerE;

  typedef struct packed {
    logic                  wrEn;      // write access on this edge
    logic                  wrReq;     // 1 = request token, 0 = release
    logic                  rdActive;  // read access active this edge
    logic                  rdCapture; // first edge of a read access
    logic [FLAG_IDX_W-1:0] idx;       // selected flag
  } portStrobeT;
endpackage

// File: rtl/sema_ctrl.sv
module sema_ctrl
  import sema_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              semN,
  input  logic              ceN,
  input  logic              weN,
  input  logic              oeN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output portStrobeT        strb
);
  logic selected;
  logic rdOn;
  logic rdPrev;
  logic unusedBits;

  assign selected = !semN && !ceN;
  assign rdOn     = selected && weN && !oeN;

  always_ff @(posedge clk) begin
    if (!rstN) rdPrev <= 1'b0;
    else       rdPrev <= rdOn;
  end

  always_comb begin
    strb.wrEn      = selected && !weN;
    strb.wrReq     = !wrData[0];
    strb.rdActive  = rdOn;
    strb.rdCapture = rdOn && !rdPrev;
    strb.idx       = addr[FLAG_IDX_W-1:0];
  end

  // upper address and data bits play no part in a semaphore access
  assign unusedBits = ^{addr[ADDR_W-1:FLAG_IDX_W], wrData[DATA_W-1:1]};
endmodule

// File: rtl/sema_datapath.sv
module sema_datapath
  import sema_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  portStrobeT           lStrb,
  input  portStrobeT           rStrb,
  output logic [DATA_W-1:0]    lRdData,
  output logic                 lRdValid,
  output logic [DATA_W-1:0]    rRdData,
  output logic                 rRdValid,
  output logic [NUM_FLAGS-1:0] reqLeft,
  output logic [NUM_FLAGS-1:0] reqRight,
  output logic [NUM_FLAGS-1:0] ownLeft,
  output logic [NUM_FLAGS-1:0] ownRight
);
  ownerE owner [NUM_FLAGS];

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    logic  reqLNext;
    logic  reqRNext;
    ownerE ownNext;

    assign reqLNext = (lStrb.wrEn && lStrb.idx == FLAG_IDX_W'(i)) ? lStrb.wrReq : reqLeft[i];
    assign reqRNext = (rStrb.wrEn && rStrb.idx == FLAG_IDX_W'(i)) ? rStrb.wrReq : reqRight[i];

    always_comb begin
      ownNext = owner[i];
      unique case (owner[i])
        OWN_LEFT:  if (!reqLNext) ownNext = reqRNext ? OWN_RIGHT : OWN_FREE;
        OWN_RIGHT: if (!reqRNext) ownNext = reqLNext ? OWN_LEFT : OWN_FREE;
        default: begin
          if (reqLNext)      ownNext = OWN_LEFT;   // tie goes left
          else if (reqRNext) ownNext = OWN_RIGHT;
          else               ownNext = OWN_FREE;
        end
      endcase
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        reqLeft[i]  <= 1'b1;
        reqRight[i] <= 1'b1;
        owner[i]    <= OWN_LEFT;
      end else begin
        reqLeft[i]  <= reqLNext;
        reqRight[i] <= reqRNext;
        owner[i]    <= ownNext;
      end
    end

    assign ownLeft[i]  = (owner[i] == OWN_LEFT);
    assign ownRight[i] = (owner[i] == OWN_RIGHT);
  end

  logic [DATA_W-1:0] rdDataA  [2];
  logic              rdValidA [2];

  for (genvar p = 0; p < 2; p++) begin : g_port
    portStrobeT           s;
    logic [NUM_FLAGS-1:0] mine;
    logic                 flagBit;

    assign s       = (p == 0) ? lStrb : rStrb;
    assign mine    = (p == 0) ? ownLeft : ownRight;
    assign flagBit = !mine[s.idx];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        rdDataA[p]  <= '0;
        rdValidA[p] <= 1'b0;
      end else if (s.rdCapture) begin
        rdDataA[p]  <= {DATA_W{flagBit}};
        rdValidA[p] <= 1'b1;
      end else if (!s.rdActive) begin
        rdDataA[p]  <= '0;
        rdValidA[p] <= 1'b0;
      end
    end
  end

  assign lRdData  = rdDataA[0];
  assign lRdValid = rdValidA[0];
  assign rRdData  = rdDataA[1];
  assign rRdValid = rdValidA[1];
endmodule

// File: rtl/sema_bank.sv
module sema_bank
  import sema_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lSemN,
  input  logic              lCeN,
  input  logic              lWeN,
  input  logic              lOeN,
  input  logic [ADDR_W-1:0] lAddr,
  input  logic [DATA_W-1:0] lWrData,
  output logic [DATA_W-1:0] lRdData,
  output logic              lRdValid,
  input  logic              rSemN,
  input  logic              rCeN,
  input  logic              rWeN,
  input  logic              rOeN,
  input  logic [ADDR_W-1:0] rAddr,
  input  logic [DATA_W-1:0] rWrData,
  output logic [DATA_W-1:0] rRdData,
  output logic              rRdValid
);
  portStrobeT           lStrb;
  portStrobeT           rStrb;
  logic [NUM_FLAGS-1:0] reqLeft;
  logic [NUM_FLAGS-1:0] reqRight;
  logic [NUM_FLAGS-1:0] ownLeft;
  logic [NUM_FLAGS-1:0] ownRight;

  sema_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) lCtrl_i (
    .clk(clk), .rstN(rstN), .semN(lSemN), .ceN(lCeN), .weN(lWeN), .oeN(lOeN),
    .addr(lAddr), .wrData(lWrData), .strb(lStrb)
  );

  sema_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) rCtrl_i (
    .clk(clk), .rstN(rstN), .semN(rSemN), .ceN(rCeN), .weN(rWeN), .oeN(rOeN),
    .addr(rAddr), .wrData(rWrData), .strb(rStrb)
  );

  sema_datapath #(.DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .lStrb(lStrb), .rStrb(rStrb),
    .lRdData(lRdData), .lRdValid(lRdValid), .rRdData(rRdData), .rRdValid(rRdValid),
    .reqLeft(reqLeft), .reqRight(reqRight), .ownLeft(ownLeft), .ownRight(ownRight)
  );
endmodule

// File: rtl/sema_bank_chk.sv
module sema_bank_chk
  import sema_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [DATA_W-1:0]    lRdData,
  input logic                 lRdValid,
  input logic [DATA_W-1:0]    rRdData,
  input logic                 rRdValid,
  input logic [NUM_FLAGS-1:0] reqLeft,
  input logic [NUM_FLAGS-1:0] reqRight,
  input logic [NUM_FLAGS-1:0] ownLeft,
  input logic [NUM_FLAGS-1:0] ownRight
);
  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flagChk
    // R4: a holder always has its own latch set
    a_r4_left_holds_latch: assert property (@(posedge clk) disable iff (!rstN)
      ownLeft[i] |-> reqLeft[i]);
    a_r4_right_holds_latch: assert property (@(posedge clk) disable iff (!rstN)
      ownRight[i] |-> reqRight[i]);
    // R4: the token stays while the holder keeps requesting
    a_r4_left_sticky: assert property (@(posedge clk) disable iff (!rstN)
      ownLeft[i] ##1 reqLeft[i] |-> ownLeft[i]);
    a_r4_right_sticky: assert property (@(posedge clk) disable iff (!rstN)
      ownRight[i] ##1 reqRight[i] |-> ownRight[i]);
    // R5: release hands the token to a pending request
    a_r5_handoff_to_right: assert property (@(posedge clk) disable iff (!rstN)
      (ownLeft[i] && reqRight[i]) ##1 (!reqLeft[i] && reqRight[i]) |-> ownRight[i]);
    a_r5_handoff_to_left: assert property (@(posedge clk) disable iff (!rstN)
      (ownRight[i] && reqLeft[i]) ##1 (reqLeft[i] && !reqRight[i]) |-> ownLeft[i]);
    // R6: no latch set means nobody holds the token
    a_r6_free_when_idle: assert property (@(posedge clk) disable iff (!rstN)
      (!reqLeft[i] && !reqRight[i]) |-> (!ownLeft[i] && !ownRight[i]));
    // R9: a same-edge claim on a free flag goes left
    a_r9_tie_left: assert property (@(posedge clk) disable iff (!rstN)
      (!reqLeft[i] && !reqRight[i]) ##1 (reqLeft[i] && reqRight[i]) |-> ownLeft[i]);
  end

  // R7: read data is all ones or all zeros
  a_r7_left_replicated: assert property (@(posedge clk) disable iff (!rstN)
    lRdValid |-> (lRdData == '0 || lRdData == '1));
  a_r7_right_replicated: assert property (@(posedge clk) disable iff (!rstN)
    rRdValid |-> (rRdData == '0 || rRdData == '1));
  // R8: idle output is zero, valid output is frozen
  a_r8_left_idle_zero: assert property (@(posedge clk) disable iff (!rstN)
    !lRdValid |-> lRdData == '0);
  a_r8_right_idle_zero: assert property (@(posedge clk) disable iff (!rstN)
    !rRdValid |-> rRdData == '0);
  a_r8_left_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (lRdValid && $past(lRdValid)) |-> $stable(lRdData));
  a_r8_right_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (rRdValid && $past(rRdValid)) |-> $stable(rRdData));
endmodule

bind sema_bank sema_bank_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rstN(rstN),
  .lRdData(lRdData), .lRdValid(lRdValid), .rRdData(rRdData), .rRdValid(rRdValid),
  .reqLeft(reqLeft), .reqRight(reqRight), .ownLeft(ownLeft), .ownRight(ownRight)
);

// File: tb/sema_bank_tb.sv
`timescale 1ns/1ps
module sema_bank_tb_top;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic              semN [2];
  logic              ceN  [2];
  logic              weN  [2];
  logic              oeN  [2];
  logic [ADDR_W-1:0] addr [2];
  logic [DATA_W-1:0] wdat [2];
  logic [DATA_W-1:0] rdat [2];
  logic              rval [2];

  sema_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut_i (
    .clk(clk), .rstN(rstN),
    .lSemN(semN[0]), .lCeN(ceN[0]), .lWeN(weN[0]), .lOeN(oeN[0]),
    .lAddr(addr[0]), .lWrData(wdat[0]), .lRdData(rdat[0]), .lRdValid(rval[0]),
    .rSemN(semN[1]), .rCeN(ceN[1]), .rWeN(weN[1]), .rOeN(oeN[1]),
    .rAddr(addr[1]), .rWrData(wdat[1]), .rRdData(rdat[1]), .rRdValid(rval[1])
  );

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int  mReqL [8];
  int  mReqR [8];
  int  mOwn  [8];   // 0 free, 1 left, 2 right
  int  mData [2];
  int  mValid[2];
  int  mPrevRd[2];

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 8; i++) begin mReqL[i] = 1; mReqR[i] = 1; mOwn[i] = 1; end
      for (int p = 0; p < 2; p++) begin mData[p] = 0; mValid[p] = 0; mPrevRd[p] = 0; end
    end else begin
      for (int p = 0; p < 2; p++) begin
        int rd;
        int f;
        rd = (semN[p] == 0 && ceN[p] == 0 && weN[p] == 1 && oeN[p] == 0) ? 1 : 0;
        f  = addr[p] % 8;
        if (rd == 1 && mPrevRd[p] == 0) begin
          mData[p]  = (mOwn[f] == p + 1) ? 0 : 255;
          mValid[p] = 1;
        end else if (rd == 0) begin
          mData[p]  = 0;
          mValid[p] = 0;
        end
        mPrevRd[p] = rd;
      end
      if (semN[0] == 0 && ceN[0] == 0 && weN[0] == 0) mReqL[addr[0] % 8] = (wdat[0] % 2 == 0) ? 1 : 0;
      if (semN[1] == 0 && ceN[1] == 0 && weN[1] == 0) mReqR[addr[1] % 8] = (wdat[1] % 2 == 0) ? 1 : 0;
      for (int i = 0; i < 8; i++) begin
        if (mOwn[i] == 1 && mReqL[i] == 0)      mOwn[i] = (mReqR[i] == 1) ? 2 : 0;
        else if (mOwn[i] == 2 && mReqR[i] == 0) mOwn[i] = (mReqL[i] == 1) ? 1 : 0;
        else if (mOwn[i] == 0)                  mOwn[i] = (mReqL[i] == 1) ? 1 : ((mReqR[i] == 1) ? 2 : 0);
      end
    end
  end

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (rstN && !finished) begin
      for (int p = 0; p < 2; p++) begin
        chk(int'(rdat[p]) == mData[p], p == 0 ? "R7 left data vs model" : "R7 right data vs model",
            int'(rdat[p]), mData[p]);
        chk(int'(rval[p]) == mValid[p], p == 0 ? "R8 left valid vs model" : "R8 right valid vs model",
            int'(rval[p]), mValid[p]);
      end
    end
  end

  // ---------------- stimulus helpers (called at posedge + 1) ----------------
  task automatic idle(input int p);
    semN[p] = 1; ceN[p] = 1; weN[p] = 1; oeN[p] = 1; addr[p] = '0; wdat[p] = '0;
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic setWrite(input int p, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    semN[p] = 0; ceN[p] = 0; weN[p] = 0; oeN[p] = 1; addr[p] = a; wdat[p] = d;
  endtask

  task automatic setRead(input int p, input logic [ADDR_W-1:0] a);
    semN[p] = 0; ceN[p] = 0; weN[p] = 1; oeN[p] = 0; addr[p] = a; wdat[p] = '0;
  endtask

  task automatic wr(input int p, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    setWrite(p, a, d); step(); idle(p);
  endtask

  task automatic rdExpect(input int p, input logic [ADDR_W-1:0] a, input int exp, input string tag);
    setRead(p, a); step();
    chk(rval[p] == 1'b1, tag, int'(rval[p]), 1);
    chk(int'(rdat[p]) == exp, tag, int'(rdat[p]), exp);
    idle(p); step();
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // ---------------- main sequence ----------------
  initial begin
    idle(0); idle(1);
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    // R8 and R10: reset state
    chk(rval[0] == 0 && rdat[0] == 0, "R8 left idle after reset", int'(rdat[0]), 0);
    rdExpect(0, 16'h0000, 8'h00, "R10 left holds flag 0 after reset");
    rdExpect(1, 16'h0000, 8'hFF, "R10 right sees flag 0 taken after reset");
    // R10: one side writing 1 hands the token over, not free yet
    wr(0, 16'h0007, 8'h01);
    rdExpect(1, 16'h0007, 8'h00, "R10 flag 7 passes to right after left frees");
    for (int i = 0; i < 8; i++) begin wr(0, ADDR_W'(i), 8'h01); wr(1, ADDR_W'(i), 8'h01); end
    for (int i = 0; i < 8; i++) begin
      rdExpect(0, ADDR_W'(i), 8'hFF, "R6 left sees free flag after init");
      rdExpect(1, ADDR_W'(i), 8'hFF, "R6 right sees free flag after init");
    end
    // R1 and R4: request with high address bits set
    wr(0, 16'hA5F3, 8'h00);
    rdExpect(0, 16'h7FFB, 8'h00, "R1 left owns flag 3 via high-bit address");
    rdExpect(1, 16'h0003, 8'hFF, "R4 right sees flag 3 taken");
    // R3 and R5: right request via bit 0 only, pending then handoff
    wr(1, 16'h0003, 8'hFE);
    rdExpect(1, 16'h0003, 8'hFF, "R5 right request pending");
    rdExpect(0, 16'h0003, 8'h00, "R5 left still owns");
    wr(0, 16'h0003, 8'h01);
    rdExpect(1, 16'h0003, 8'h00, "R5 right gains flag 3 on release");
    rdExpect(0, 16'h0003, 8'hFF, "R5 left sees flag 3 taken");
    wr(1, 16'h0003, 8'h03);
    rdExpect(0, 16'h0003, 8'hFF, "R6 flag 3 free after right release");
    rdExpect(1, 16'h0003, 8'hFF, "R6 right sees flag 3 free");
    // R9: tie on the same edge
    setWrite(0, 16'h0005, 8'h00); setWrite(1, 16'h0005, 8'h00); step(); idle(0); idle(1);
    rdExpect(0, 16'h0005, 8'h00, "R9 left wins tie");
    rdExpect(1, 16'h0005, 8'hFF, "R9 right loses tie");
    wr(0, 16'h0005, 8'h01);
    rdExpect(1, 16'h0005, 8'h00, "R5 right gets flag 5 after tie");
    wr(1, 16'h0005, 8'h01);
    // R2: writes without select or chip enable have no effect
    semN[0] = 1; ceN[0] = 0; weN[0] = 0; addr[0] = 16'h0001; wdat[0] = 8'h00; step(); idle(0);
    semN[0] = 0; ceN[0] = 1; weN[0] = 0; addr[0] = 16'h0001; wdat[0] = 8'h00; step(); idle(0);
    rdExpect(0, 16'h0001, 8'hFF, "R2 unselected write ignored");
    semN[1] = 0; ceN[1] = 1; weN[1] = 1; oeN[1] = 0; addr[1] = 16'h0001; step();
    chk(rval[1] == 0, "R2 no read without chip enable", int'(rval[1]), 0);
    idle(1); step();
    // R4: non-owner release does not steal
    wr(0, 16'h0006, 8'h00);
    wr(1, 16'h0006, 8'h01);
    rdExpect(0, 16'h0006, 8'h00, "R4 left keeps flag 6");
    wr(0, 16'h0006, 8'h01);
    rdExpect(1, 16'h0006, 8'hFF, "R6 flag 6 free");
    // R8: frozen read across a handoff
    wr(1, 16'h0002, 8'h00);
    wr(0, 16'h0002, 8'h00);
    setRead(0, 16'h0002); step();
    chk(rdat[0] == 8'hFF, "R8 left captured taken flag", int'(rdat[0]), 8'hFF);
    setWrite(1, 16'h0002, 8'h01); step(); idle(1);
    step();
    chk(rdat[0] == 8'hFF, "R8 left read frozen after handoff", int'(rdat[0]), 8'hFF);
    oeN[0] = 1; step();
    chk(rval[0] == 0 && rdat[0] == 0, "R8 output cleared when oe drops", int'(rdat[0]), 0);
    oeN[0] = 0; step();
    chk(rdat[0] == 8'h00, "R8 re-read shows left now owns", int'(rdat[0]), 8'h00);
    idle(0); step();
    wr(0, 16'h0002, 8'h01);
    // random phase, model compared each clock
    for (int n = 0; n < 4000; n++) begin
      for (int p = 0; p < 2; p++) begin
        semN[p] = ($urandom % 4) == 0;
        ceN[p]  = ($urandom % 6) == 0;
        weN[p]  = ($urandom % 2) == 0;
        oeN[p]  = ($urandom % 5) == 0;
        addr[p] = ADDR_W'($urandom);
        wdat[p] = DATA_W'($urandom);
      end
      step();
    end
    idle(0); idle(1); step(); step();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule